// File: doc/BRIEF.md
# Stereo Soft-Mute Gain Ramp

This block sits in a stereo sample path and scales both channels by a shared linear gain. When the mute request goes high, the gain falls by one count on each frame strobe until the samples are exactly zero. When the request drops, the gain climbs back by one count per strobe until it reaches unity. A full sweep in either direction takes 2^RAMP_LOG2 frames, which is 1024 at the default setting. If the request changes partway through a sweep, the gain turns around at its present count; it does not jump back to either end.

Each strobe registers one scaled left/right pair, using the gain that was in force before that strobe's step. When the power-enable input is low, both outputs are forced to zero in the same cycle and the gain is held at unity. After power-enable returns high, the block resumes normal operation from unity gain.

Top module: `smute_ramp`

## Requirements
- R1: After reset both outputs read zero, and the gain starts at unity, so the first strobed pair passes through unchanged.
- R2: While mute_req is high, every frame strobe lowers the gain count by exactly one until it reaches 0. Each strobe outputs the pair scaled by the gain that was in force before that strobe's step.
- R3: Once the gain count is 0, every strobed output pair is exactly zero, whatever the input.
- R4: While mute_req is low, every frame strobe raises the gain count by exactly one until it reaches unity (2^RAMP_LOG2), where it stays.
- R5: When mute_req changes during a sweep, the next strobe steps from the current count in the new direction, with no jump.
- R6: For a gain count g below unity, each output equals floor(x*g / 2^RAMP_LOG2), where x is the signed two's-complement input. At unity the input passes through bit-exact.
- R7: Both channels are always scaled by the same gain count, which is updated on the same strobe.
- R8: While pwr_en is low, both outputs read zero in that same cycle and the gain returns to unity. After release, the outputs stay zero until the next strobe, and that strobe uses unity gain.
- R9: In cycles without a frame strobe, neither the outputs nor the gain change, even when mute_req toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Low forces zero output and unity gain |
| mute_req | input | 1 | High ramps toward mute, low ramps toward unity |
| frame_stb | input | 1 | One-cycle pulse per stereo frame |
| in_l | input | DATA_W (24) | Left input sample, signed |
| in_r | input | DATA_W (24) | Right input sample, signed |
| out_l | output | DATA_W (24) | Left scaled sample, signed |
| out_r | output | DATA_W (24) | Right scaled sample, signed |

## Verification
The hardest situation to reach is a reversal deep inside a sweep. Reaching it takes hundreds of consecutive strobes, and the flip must be checked against the exact count where the gain stood. The stimulus runs a complete fall to zero and then a partial rise. It then reverses for a fixed number of frames and rises again all the way to unity. A bench-side gain model predicts every strobed pair. A second hard case is a power-down in the middle of a ramp, because the reset to unity only shows on the first strobe after release. The bench cuts power after a partial fall and checks that the next pair comes out unattenuated.

// File: rtl/smr_pkg.sv
`timescale 1ns/1ps
package smr_pkg;
  localparam int DEF_DATA_W    = 24;
  localparam int DEF_RAMP_LOG2 = 10;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_FALL = 2'd1,
    RAMP_RISE = 2'd2
  } ramp_dir_e;
endpackage

// File: rtl/smr_gain_ctrl.sv
`timescale 1ns/1ps
module smr_gain_ctrl
  import smr_pkg::*;
#(
  parameter int RAMP_LOG2 = DEF_RAMP_LOG2,
  localparam int GAIN_W = RAMP_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              mute_req,
  input  logic              frame_stb,
  output logic [GAIN_W-1:0] gain
);
  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {RAMP_LOG2{1'b0}}};

  logic [GAIN_W-1:0] gain_q;
  ramp_dir_e         dir;
  logic              at_zero;
  logic              at_unity;

  assign at_zero  = (gain_q == '0);
  assign at_unity = (gain_q == UNITY);

  always_comb begin
    dir = RAMP_HOLD;
    if (frame_stb) begin
      if (mute_req && !at_zero)        dir = RAMP_FALL;
      else if (!mute_req && !at_unity) dir = RAMP_RISE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= UNITY;
    end else if (!pwr_en) begin
      gain_q <= UNITY;
    end else begin
      case (dir)
        RAMP_FALL: gain_q <= gain_q - 1'b1;
        RAMP_RISE: gain_q <= gain_q + 1'b1;
        default:   gain_q <= gain_q;
      endcase
    end
  end

  assign gain = gain_q;
endmodule

// File: rtl/smr_scaler.sv
`timescale 1ns/1ps
module smr_scaler
  import smr_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int RAMP_LOG2 = DEF_RAMP_LOG2,
  localparam int GAIN_W = RAMP_LOG2 + 1,
  localparam int PROD_W = DATA_W + GAIN_W + 1
) (
  input  logic [DATA_W-1:0] din,
  input  logic [GAIN_W-1:0] gain,
  output logic [DATA_W-1:0] dout
);
  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {RAMP_LOG2{1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic                     unused_prod_bits;

  assign prod = $signed(din) * $signed({1'b0, gain});
  assign unused_prod_bits = ^{prod[PROD_W-1:DATA_W+RAMP_LOG2], prod[RAMP_LOG2-1:0]};

  always_comb begin
    if (gain == UNITY) dout = din;
    else               dout = prod[RAMP_LOG2 +: DATA_W];
  end
endmodule

// File: rtl/smute_ramp.sv
`timescale 1ns/1ps
module smute_ramp
  import smr_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int RAMP_LOG2 = DEF_RAMP_LOG2,
  localparam int GAIN_W = RAMP_LOG2 + 1,
  localparam int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              mute_req,
  input  logic              frame_stb,
  input  logic [DATA_W-1:0] in_l,
  input  logic [DATA_W-1:0] in_r,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_r
);
  logic [GAIN_W-1:0] gain_cur;
  logic [DATA_W-1:0] ch_in  [NCH];
  logic [DATA_W-1:0] ch_scl [NCH];
  logic [DATA_W-1:0] ch_q   [NCH];

  assign ch_in[0] = in_l;
  assign ch_in[1] = in_r;

  smr_gain_ctrl #(.RAMP_LOG2(RAMP_LOG2)) u_gain (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_en    (pwr_en),
    .mute_req  (mute_req),
    .frame_stb (frame_stb),
    .gain      (gain_cur)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smr_scaler #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_scl (
      .din  (ch_in[c]),
      .gain (gain_cur),
      .dout (ch_scl[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ch_q[c] <= '0;
      else if (!pwr_en)   ch_q[c] <= '0;
      else if (frame_stb) ch_q[c] <= ch_scl[c];
    end
  end

  assign out_l = pwr_en ? ch_q[0] : '0;
  assign out_r = pwr_en ? ch_q[1] : '0;
endmodule

// File: rtl/smr_checker.sv
`timescale 1ns/1ps
module smr_checker #(
  parameter int DATA_W    = 24,
  parameter int RAMP_LOG2 = 10,
  localparam int GAIN_W = RAMP_LOG2 + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_en,
  input logic              mute_req,
  input logic              frame_stb,
  input logic [DATA_W-1:0] in_l,
  input logic [DATA_W-1:0] in_r,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r,
  input logic [GAIN_W-1:0] gain
);
  localparam logic [GAIN_W-1:0] UNITY = {1'b1, {RAMP_LOG2{1'b0}}};

  p_gain_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= UNITY);

  p_fall_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && frame_stb && mute_req && gain != '0)
    |=> (!pwr_en || gain == $past(gain) - 1'b1));

  p_rise_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && frame_stb && !mute_req && gain != UNITY)
    |=> (!pwr_en || gain == $past(gain) + 1'b1));

  p_zero_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && frame_stb && gain == '0)
    |=> (!pwr_en || (out_l == '0 && out_r == '0)));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && frame_stb && gain == UNITY)
    |=> (!pwr_en || (out_l == $past(in_l) && out_r == $past(in_r))));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !frame_stb)
    |=> (!pwr_en || ($stable(gain) && $stable(out_l) && $stable(out_r))));

  p_pd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (out_l == '0 && out_r == '0));

  p_pd_unity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> gain == UNITY);
endmodule

bind smute_ramp smr_checker #(.DATA_W(DATA_W), .RAMP_LOG2(RAMP_LOG2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_en    (pwr_en),
  .mute_req  (mute_req),
  .frame_stb (frame_stb),
  .in_l      (in_l),
  .in_r      (in_r),
  .out_l     (out_l),
  .out_r     (out_r),
  .gain      (gain_cur)
);

// File: tb/smute_ramp_test.sv
`timescale 1ns/1ps
module smute_ramp_test;
  localparam int DW   = 24;
  localparam int FULL = 1024;

  typedef struct {
    int    l;
    int    r;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_en = 1'b1;
  logic          mute_req = 1'b0;
  logic          frame_stb = 1'b0;
  logic [DW-1:0] in_l = '0;
  logic [DW-1:0] in_r = '0;
  logic [DW-1:0] out_l;
  logic [DW-1:0] out_r;

  int   n_chk = 0;
  int   n_bad = 0;
  int   mg = FULL;
  int   last_l = 0;
  int   last_r = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  smute_ramp uut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .mute_req(mute_req),
    .frame_stb(frame_stb), .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r)
  );

  function automatic int scale_ref(int x, int g);
    longint p;
    if (g >= FULL) return x;
    p = longint'(x) * longint'(g);
    if (p >= 0) return int'(p / 1024);
    return -int'((-p + 1023) / 1024);
  endfunction

  function automatic int pat(int i, int ch);
    if ((i + ch) % 97 == 0) return 8388607;
    if ((i + ch) % 89 == 0) return -8388608;
    if ((i + ch) % 13 == 0) return -1;
    return ((i * 40503 + ch * 12345 + 777) % 16777216) - 8388608;
  endfunction

  task automatic check(string tag, int al, int ar, int el, int er);
    n_chk++;
    if (al != el || ar != er) begin
      n_bad++;
      $display("FAIL %s: actual l=%0d r=%0d expected l=%0d r=%0d", tag, al, ar, el, er);
    end
  endtask

  task automatic frame(int l, int r, bit mute, string tag);
    exp_t e;
    @(negedge clk);
    in_l = DW'(l);
    in_r = DW'(r);
    mute_req = mute;
    frame_stb = 1'b1;
    e.l = scale_ref(l, mg);
    e.r = scale_ref(r, mg);
    e.tag = tag;
    sb.push_back(e);
    last_l = e.l;
    last_r = e.r;
    if (mute && mg > 0) mg--;
    else if (!mute && mg < FULL) mg++;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frame_stb = 1'b0;
    end
  endtask

  task automatic run(int n, int base, bit mute, string tag);
    for (int k = 0; k < n; k++) frame(pat(base + k, 0), pat(base + k, 1), mute, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      if (frame_stb && rst_n) begin
        @(negedge clk);
        #1;
        if (sb.size() == 0) begin
          check("R2 queue", 0, 0, 1, 1);
        end else begin
          e = sb.pop_front();
          check(e.tag, $signed(out_l), $signed(out_r), e.l, e.r);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1 check("R1 reset", $signed(out_l), $signed(out_r), 0, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 idle after reset", $signed(out_l), $signed(out_r), 0, 0);
    // R1 / R6: unity bypass at start, including extremes
    frame(8388607, -8388608, 1'b0, "R1 first pair bypass");
    frame(-1, 1, 1'b0, "R6 unity small");
    run(3, 5, 1'b0, "R6 unity bypass");
    // R9: toggling mute without strobes leaves outputs alone
    idle(1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      mute_req = k[0];
      #1 check("R9 no strobe hold", $signed(out_l), $signed(out_r), last_l, last_r);
    end
    // R2 / R6 / R7: full fall to zero, then R3 at zero
    frame(-1, -1, 1'b1, "R2 first fall frame");
    frame(-1, 1023, 1'b1, "R6 floor of -1 at 1023");
    frame(4096, 4096, 1'b1, "R7 shared gain equal inputs");
    run(1021, 100, 1'b1, "R2 falling ramp");
    run(6, 2000, 1'b1, "R3 zero at full mute");
    frame(8388607, -8388608, 1'b1, "R3 zero extremes");
    // R9 at zero with mute low and no strobe
    idle(1);
    @(negedge clk);
    mute_req = 1'b0;
    #1 check("R9 hold at mute", $signed(out_l), $signed(out_r), 0, 0);
    // R4 partial rise, R5 reversal, then R4 to unity and beyond
    run(300, 3000, 1'b0, "R4 rising ramp");
    run(100, 4000, 1'b1, "R5 reversal falling");
    run(80, 5000, 1'b0, "R5 reversal rising");
    run(830, 6000, 1'b0, "R4 rise to unity");
    frame(-8388608, 8388607, 1'b0, "R4 unity held");
    // R8: power-down mid fall
    run(400, 8000, 1'b1, "R2 fall before power-down");
    idle(1);
    @(negedge clk);
    pwr_en = 1'b0;
    #1 check("R8 zero same cycle", $signed(out_l), $signed(out_r), 0, 0);
    idle(3);
    #1 check("R8 zero held", $signed(out_l), $signed(out_r), 0, 0);
    @(negedge clk);
    pwr_en = 1'b1;
    mg = FULL;
    #1 check("R8 zero after release", $signed(out_l), $signed(out_r), 0, 0);
    frame(1234567, -7654321, 1'b0, "R8 resumes at unity");
    run(4, 9000, 1'b0, "R8 resumed bypass");
    idle(4);
    if (sb.size() != 0) check("R2 queue drained", sb.size(), 0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule